// File: doc/BRIEF.md
# Dual-Channel Printhead Row Address Selector

This block produces the row (address) select lines for two printheads, thirteen lines per head. Only one head is served at a time: a head-select input steers the decoded row to bus A or bus B. An active-low head enable gates the output. While the enable is high, both buses stay at zero.

The row number comes from one of two sources. In direct mode, a four-bit select word drives the decoder as a binary row code, so an external controller can run any scanning order it likes. In counter mode, the same select pins take new roles. Bit 0 becomes a count strobe, bit 1 becomes an active-low counter clear, and bit 2 sets the count direction. An internal modulo-13 counter then walks the rows, and the decoder asserts the row that matches the count.

All pins are sampled on a system clock. A count step happens on the system clock edge where the strobe is first seen high after it was seen low.

Top module: `row_addr_sel`

## Requirements
- R1: `head_sel` = 0 routes the decoded row to `rows_a`, and `head_sel` = 1 routes it to `rows_b`. The other bus reads all zero, and at most one bit of each bus is high.
- R2: While `head_en_n` is 1, `rows_a` and `rows_b` are both all zero, whatever the mode or the select word.
- R3: With `cnt_mode` = 0, the decoder takes `sel[3:0]` as a binary row code, with `sel[0]` as the least significant bit. Code k asserts bit k of the selected bus.
- R4: With `cnt_mode` = 0, codes 13, 14 and 15 assert no row line on either bus.
- R5: With `cnt_mode` = 1 and `sel[2]` = 1, each rising edge of `sel[0]` adds one to the count, and 12 wraps to 0. The new row shows on the outputs right after the clock edge where the strobe is sampled high.
- R6: With `cnt_mode` = 1 and `sel[2]` = 0, each rising edge of `sel[0]` subtracts one from the count, and 0 wraps to 12.
- R7: With `cnt_mode` = 1, the count is forced to 0 on every clock edge where `sel[1]` is sampled low. This clear wins over a strobe edge in the same cycle.
- R8: Holding `sel[0]` high gives only one step. After `rst_n` is released, a strobe that is already high does not count until it has been seen low.
- R9: With `cnt_mode` = 0, the count holds its value, and activity on `sel` neither steps nor clears it.
- R10: While `rst_n` is 0, the count is forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the counter |
| cnt_mode | input | 1 | 1 = internal counter drives the decoder, 0 = `sel` drives it directly |
| head_sel | input | 1 | 0 = head A bus, 1 = head B bus |
| head_en_n | input | 1 | Active-low enable of the selected bus |
| sel | input | 4 | Direct row code, or strobe/clear/direction in counter mode |
| rows_a | output | 13 | One-hot row select for head A |
| rows_b | output | 13 | One-hot row select for head B |

## Verification
The bench builds the block with its default of 13 rows. At that size the select word is four bits wide, so three direct codes fall past the last row (R4), and both counter wrap points, 12 to 0 going up and 0 to 12 going down, come within reach after a few strobes. A bench-side row model predicts every bus value. With it, a full direct-code sweep on both heads, strobes held across several cycles, and a clear issued together with a strobe are each checked against a value that does not depend on the RTL.

// File: rtl/row_sel_pkg.sv
package row_sel_pkg;
    localparam int DEF_ROWS = 13;

    typedef enum logic {
        HEAD_A = 1'b0,
        HEAD_B = 1'b1
    } head_e;
endpackage

// File: rtl/row_counter.sv
module row_counter #(
    parameter int ROWS = row_sel_pkg::DEF_ROWS,
    parameter int CW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_cnt,
    input  logic          strobe,
    input  logic          clr_n,
    input  logic          up,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe;
        if (mode_cnt) begin
            if (!clr_n) begin
                st_d.cnt = '0;
            end else if (strobe && !st_q.strobe_prev) begin
                if (up) begin
                    st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
                end else begin
                    st_d.cnt = (st_q.cnt == '0) ? LAST : st_q.cnt - CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt         <= '0;
            st_q.strobe_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/row_decoder.sv
module row_decoder #(
    parameter int ROWS = row_sel_pkg::DEF_ROWS,
    parameter int CW   = $clog2(ROWS)
) (
    input  logic [CW-1:0]   code,
    output logic [ROWS-1:0] onehot
);
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign onehot[i] = (code == CW'(i));
    end
endmodule

// File: rtl/head_steer.sv
module head_steer #(
    parameter int ROWS = row_sel_pkg::DEF_ROWS
) (
    input  logic [ROWS-1:0] onehot,
    input  logic            head_sel,
    input  logic            en_n,
    output logic [ROWS-1:0] bus_a,
    output logic [ROWS-1:0] bus_b
);
    import row_sel_pkg::*;

    head_e head;

    always_comb begin
        head  = head_e'(head_sel);
        bus_a = '0;
        bus_b = '0;
        if (!en_n) begin
            if (head == HEAD_A) begin
                bus_a = onehot;
            end else begin
                bus_b = onehot;
            end
        end
    end
endmodule

// File: rtl/row_addr_sel.sv
module row_addr_sel #(
    parameter int ROWS = row_sel_pkg::DEF_ROWS,
    parameter int CW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_mode,
    input  logic            head_sel,
    input  logic            head_en_n,
    input  logic [3:0]      sel,
    output logic [ROWS-1:0] rows_a,
    output logic [ROWS-1:0] rows_b
);
    logic [CW-1:0]   row_cnt;
    logic [CW-1:0]   code;
    logic [ROWS-1:0] onehot;

    row_counter #(.ROWS(ROWS), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_cnt (cnt_mode),
        .strobe   (sel[0]),
        .clr_n    (sel[1]),
        .up       (sel[2]),
        .count    (row_cnt)
    );

    always_comb begin
        code = cnt_mode ? row_cnt : CW'(sel);
    end

    row_decoder #(.ROWS(ROWS), .CW(CW)) u_dec (
        .code   (code),
        .onehot (onehot)
    );

    head_steer #(.ROWS(ROWS)) u_steer (
        .onehot   (onehot),
        .head_sel (head_sel),
        .en_n     (head_en_n),
        .bus_a    (rows_a),
        .bus_b    (rows_b)
    );
endmodule

// File: rtl/row_addr_sel_chk.sv
module row_addr_sel_chk #(
    parameter int ROWS = row_sel_pkg::DEF_ROWS,
    parameter int CW   = $clog2(ROWS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cnt_mode,
    input logic            head_sel,
    input logic            head_en_n,
    input logic [3:0]      sel,
    input logic [ROWS-1:0] rows_a,
    input logic [ROWS-1:0] rows_b,
    input logic [CW-1:0]   row_cnt
);
    // R1: never both heads, never two rows
    a_r1_one_head: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rows_a) && $onehot0(rows_b) && !((|rows_a) && (|rows_b)));

    // R1: the bus that is not selected stays quiet
    a_r1_quiet_other: assert property (@(posedge clk) disable iff (!rst_n)
        head_sel ? (rows_a == '0) : (rows_b == '0));

    a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        head_en_n |-> (rows_a == '0) && (rows_b == '0));

    a_r4_no_row_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_mode && (32'(sel) >= ROWS)) |-> (rows_a == '0) && (rows_b == '0));

    // R5, R6: count stays in range
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(row_cnt) < ROWS);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && !sel[1]) |=> (row_cnt == '0));

    a_r8_no_strobe_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && sel[1] && !sel[0]) |=> $stable(row_cnt));

    a_r9_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_mode |=> $stable(row_cnt));
endmodule

bind row_addr_sel row_addr_sel_chk #(.ROWS(ROWS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_mode  (cnt_mode),
    .head_sel  (head_sel),
    .head_en_n (head_en_n),
    .sel       (sel),
    .rows_a    (rows_a),
    .rows_b    (rows_b),
    .row_cnt   (row_cnt)
);

// File: tb/tb_row_addr_sel.sv
module tb_row_addr_sel;
    localparam int ROWS = 13;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cnt_mode;
    logic            head_sel;
    logic            head_en_n;
    logic [3:0]      sel;
    logic [ROWS-1:0] rows_a;
    logic [ROWS-1:0] rows_b;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    row_addr_sel #(.ROWS(ROWS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_mode  (cnt_mode),
        .head_sel  (head_sel),
        .head_en_n (head_en_n),
        .sel       (sel),
        .rows_a    (rows_a),
        .rows_b    (rows_b)
    );

    function automatic logic [ROWS-1:0] oh(input int k);
        return (k >= 0 && k < ROWS) ? (ROWS'(1) << k) : '0;
    endfunction

    task automatic check(input string tag, input logic [ROWS-1:0] act,
                         input logic [ROWS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Checks both buses for row k under the current head, enable and mode
    task automatic check_rows(input string tag, input int k);
        logic [ROWS-1:0] ea, eb;
        ea = '0;
        eb = '0;
        if (!head_en_n) begin
            if (head_sel) eb = oh(k);
            else          ea = oh(k);
        end
        check({tag, " bus A"}, rows_a, ea);
        check({tag, " bus B"}, rows_b, eb);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic strobe();
        sel[0] = 1'b1;
        step();
        sel[0] = 1'b0;
        step();
        if (sel[2]) exp_cnt = (exp_cnt == ROWS - 1) ? 0 : exp_cnt + 1;
        else        exp_cnt = (exp_cnt == 0) ? ROWS - 1 : exp_cnt - 1;
    endtask

    task automatic do_reset(input logic s0);
        rst_n     = 1'b0;
        cnt_mode  = 1'b1;
        head_sel  = 1'b0;
        head_en_n = 1'b0;
        sel       = {3'b011, s0};
        step();
        step();
        rst_n = 1'b1;
        step();
        exp_cnt = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check_rows("R10 reset row 0", 0);
    endtask

    task automatic t_disable();
        head_en_n = 1'b1;
        #1;
        check_rows("R2 disabled counter mode", 0);
        cnt_mode = 1'b0;
        sel      = 4'd5;
        #1;
        check_rows("R2 disabled direct mode", 5);
        head_en_n = 1'b0;
        cnt_mode  = 1'b1;
        sel       = 4'b0110;
        step();
    endtask

    task automatic t_direct();
        cnt_mode = 1'b0;
        for (int h = 0; h < 2; h++) begin
            head_sel = h[0];
            for (int c = 0; c < 16; c++) begin
                sel = 4'(c);
                #1;
                if (c < ROWS) check_rows(h ? "R3 R1 direct head B" : "R3 R1 direct head A", c);
                else          check_rows("R4 unused code", c);
            end
        end
        head_sel = 1'b0;
        sel      = 4'b0110;
        cnt_mode = 1'b1;
        step();
    endtask

    task automatic t_count_up();
        sel = 4'b0110;
        for (int i = 0; i < 14; i++) begin
            strobe();
            check_rows("R5 count up", exp_cnt);
        end
        head_sel = 1'b1;
        #1;
        check_rows("R1 counter to head B", exp_cnt);
        head_sel = 1'b0;
    endtask

    task automatic t_count_down();
        sel = 4'b0010;
        step();
        for (int i = 0; i < 4; i++) begin
            strobe();
            check_rows("R6 count down", exp_cnt);
        end
        sel = 4'b0000;
        step();
        exp_cnt = 0;
        check_rows("R7 clear", 0);
        sel = 4'b0010;
        step();
        strobe();
        check_rows("R6 wrap 0 to 12", 12);
    endtask

    task automatic t_clear_priority();
        sel = 4'b0110;
        step();
        strobe();
        strobe();
        sel = 4'b0101;
        step();
        exp_cnt = 0;
        check_rows("R7 clear beats strobe", 0);
        sel = 4'b0110;
        step();
        check_rows("R7 count stays 0 after clear", 0);
    endtask

    task automatic t_hold_strobe();
        sel = 4'b0110;
        step();
        sel[0] = 1'b1;
        step();
        step();
        step();
        exp_cnt = exp_cnt + 1;
        check_rows("R8 held strobe steps once", exp_cnt);
        sel[0] = 1'b0;
        step();
        do_reset(1'b1);
        step();
        step();
        check_rows("R8 strobe high at reset release", 0);
        sel[0] = 1'b0;
        step();
        sel[0] = 1'b1;
        step();
        exp_cnt = 1;
        check_rows("R8 first real strobe", 1);
        sel[0] = 1'b0;
        step();
    endtask

    task automatic t_direct_hold();
        sel = 4'b0110;
        for (int i = 0; i < 4; i++) strobe();
        cnt_mode = 1'b0;
        sel      = 4'b0100;
        step();
        sel = 4'b0101;
        step();
        sel = 4'b0000;
        step();
        sel = 4'b0111;
        step();
        sel = 4'b0110;
        step();
        cnt_mode = 1'b1;
        #1;
        check_rows("R9 count kept through direct mode", exp_cnt);
    endtask

    initial begin
        t_reset();
        t_disable();
        t_direct();
        t_count_up();
        t_count_down();
        t_clear_priority();
        t_hold_strobe();
        t_direct_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule